// File: doc/BRIEF.md
# Interline CCD Drive Timing Generator

This block produces every digital timing signal needed to drive an interline-transfer CCD sensor that is read out as two interlaced fields per frame. From a single clock running at twice the pixel rate it derives a pixel phase, a pixel position within the line and a line position within the frame. It decodes these positions into the four-phase vertical shift clocks, the two photosite readout pulses, the complementary horizontal shift clocks, the per-pixel reset-gate pulse, the substrate drain pulse of the electronic shutter, and the line, frame, field and blanking markers. A downstream analog driver stage translates these logic levels into sensor voltages.

A line begins with a horizontal blanking stretch, during which the vertical register moves one row and the shutter may drain the photosites. Dummy register stages, leading optical-black columns, effective columns and trailing optical-black columns follow. The first line of each field is the readout line. On that line the vertical register does not step, and the two readout pulses fire in an order that depends on the field, so that adjacent rows pair differently in the two fields. The storage time is set by an external line count, which the block samples once per frame.

Top module: `ccd_timing_gen`

## Requirements
- R1: While reset is held, the outputs are: vertical phases 4'b0011 (bit i carries phase i+1, so V1 and V2 are high), h1 high, h2 low, blk high, and every other output low.
- R2: A pixel takes two clocks and a line takes LINE_LEN pixels, where LINE_LEN = HBLANK + DUMMY + OB_LEAD + EFF_PIX + OB_TRAIL. All outputs are registered. hd is a one-clock strobe on the first clock of each line, and it appears on the first clock edge after reset is released.
- R3: A frame has FRAME_LINES lines. Field 0 is the first (FRAME_LINES+1)/2 lines and field 1 is the rest. fld is high throughout field 1, so it changes only at field starts. vd is a one-clock strobe on the first clock of line 0.
- R4: On pixel positions at or above HBLANK, h1 is high on the first clock of each pixel and h2 is high on the second. During horizontal blanking, h1 is held high and h2 is held low.
- R5: rg is high on the first clock of every pixel outside horizontal blanking, and never while h1 is low.
- R6: On every line except the first line of a field, the vertical phases leave the idle pair {V1,V2} at pixel V_POS. They pass through {V2,V3}, {V3,V4} and {V4,V1}, each held for V_STEP pixels, and then return to {V1,V2}. Exactly two adjacent phases are high at all times.
- R7: Readout pulses fire only on the first line of a field. Each pulse is RD_W pixels wide, one starting at pixel RD_A and the other at pixel RD_B. In field 0 the phase-1 pulse uses RD_A and the phase-3 pulse uses RD_B; field 1 swaps them. The vertical phases stay idle on this line.
- R8: On field line n ≥ 1 of a field with L lines, the substrate pulse is high over pixels SUB_POS to SUB_POS+SUB_W-1 exactly when L − n exceeds the latched shutter setting. A setting of L−1 or more therefore gives no drain pulses in that field.
- R9: The shutter setting is captured only at the frame start, on the clock of the vd strobe. A change made at any other point in a frame affects only the next frame.
- R10: blk is low exactly when the pixel lies in the effective columns (HBLANK+DUMMY+OB_LEAD up to EFF_PIX pixels later) and the field line lies in the effective rows (V_START+V_OB_LEAD up to V_EFF lines later). It is high everywhere else.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutter_lines | input | SHUT_W | Storage time in lines, sampled at frame start |
| v_phase | output | 4 | Vertical transfer phases V1..V4 (bit 0 = V1) |
| rd_ph1 | output | 1 | Photosite readout pulse on phase 1 |
| rd_ph3 | output | 1 | Photosite readout pulse on phase 3 |
| h1 | output | 1 | Horizontal transfer phase 1 |
| h2 | output | 1 | Horizontal transfer phase 2 |
| rg | output | 1 | Reset-gate pulse |
| sub_pulse | output | 1 | Substrate drain (electronic shutter) pulse |
| hd | output | 1 | Line start strobe |
| vd | output | 1 | Frame start strobe |
| fld | output | 1 | Field flag, high in field 1 |
| blk | output | 1 | Blanking, high outside the effective area |

## Verification
The bench shrinks the block to a 21-pixel line with a 12-pixel blanking stretch and a 21-line frame (fields of 11 and 10 lines), with 2-pixel vertical steps and 3-pixel readout and drain windows. With these values, thirteen complete frames take about eleven thousand clocks. Every output is compared against arithmetic expectations on every clock. The frames sweep the shutter setting from 0 up to values beyond the field length, which reaches the cases of all-lines drain, partial drain and no drain in both field sizes. Halfway through each frame the bench writes a different shutter value, so each frame also shows that a mid-frame write has no effect.

// File: rtl/ccdt_pkg.sv
package ccdt_pkg;

  // idle vertical state: phases 1 and 2 high
  localparam logic [3:0] V_IDLE = 4'b0011;

  // rotate a four-phase pattern toward higher phase numbers
  function automatic logic [3:0] vrot(input logic [3:0] p, input int unsigned n);
    case (n % 4)
      0:       return p;
      1:       return {p[2:0], p[3]};
      2:       return {p[1:0], p[3:2]};
      default: return {p[0], p[3:1]};
    endcase
  endfunction

endpackage

// File: rtl/ccdt_counters.sv
module ccdt_counters #(
  parameter int unsigned LINE_LEN    = 606,
  parameter int unsigned FRAME_LINES = 525,
  parameter int unsigned PIX_W       = 10,
  parameter int unsigned LINE_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              ph,
  output logic [PIX_W-1:0]  pix,
  output logic [LINE_W-1:0] line
);

  localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(LINE_LEN - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(FRAME_LINES - 1);

  logic              ph_q, ph_n;
  logic [PIX_W-1:0]  pix_q, pix_n;
  logic [LINE_W-1:0] line_q, line_n;
  logic              pix_en, line_en;

  always_comb begin
    ph_n    = ~ph_q;
    pix_en  = ph_q;
    line_en = ph_q && (pix_q == PIX_LAST);
    pix_n   = (pix_q == PIX_LAST) ? '0 : pix_q + 1'b1;
    line_n  = (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      pix_q  <= '0;
      line_q <= '0;
    end else begin
      ph_q <= ph_n;
      if (pix_en)  pix_q  <= pix_n;
      if (line_en) line_q <= line_n;
    end
  end

  assign ph   = ph_q;
  assign pix  = pix_q;
  assign line = line_q;

  a_r2_pix_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q && pix_q == PIX_LAST) |=> (pix_q == '0));
  a_r2_pix_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_q |=> $stable(pix_q));
  a_r3_line_range: assert property (@(posedge clk) disable iff (!rst_n)
    line_q <= LINE_LAST);

endmodule

// File: rtl/ccdt_horiz.sv
module ccdt_horiz #(
  parameter int unsigned HBLANK   = 53,
  parameter int unsigned EFF_LO   = 71,
  parameter int unsigned EFF_PIX  = 510,
  parameter int unsigned PIX_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph,
  input  logic [PIX_W-1:0] pix,
  output logic             h1,
  output logic             h2,
  output logic             rg,
  output logic             hd,
  output logic             h_eff
);

  logic [31:0] px;
  logic        active;
  logic        h1_n, h2_n, rg_n, hd_n, eff_n;
  logic        h1_q, h2_q, rg_q, hd_q, eff_q;

  assign px = 32'(pix);

  always_comb begin
    active = (px >= HBLANK);
    h1_n   = active ? ~ph : 1'b1;
    h2_n   = active ? ph : 1'b0;
    rg_n   = active && !ph;
    hd_n   = (px == 0) && !ph;
    eff_n  = (px >= EFF_LO) && (px < EFF_LO + EFF_PIX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1_q  <= 1'b1;
      h2_q  <= 1'b0;
      rg_q  <= 1'b0;
      hd_q  <= 1'b0;
      eff_q <= 1'b0;
    end else begin
      h1_q  <= h1_n;
      h2_q  <= h2_n;
      rg_q  <= rg_n;
      hd_q  <= hd_n;
      eff_q <= eff_n;
    end
  end

  assign h1    = h1_q;
  assign h2    = h2_q;
  assign rg    = rg_q;
  assign hd    = hd_q;
  assign h_eff = eff_q;

  a_r4_complementary: assert property (@(posedge clk) disable iff (!rst_n)
    h1_q != h2_q);
  a_r5_rg_within_h1: assert property (@(posedge clk) disable iff (!rst_n)
    rg_q |-> h1_q);
  a_r2_hd_single: assert property (@(posedge clk) disable iff (!rst_n)
    hd_q |=> !hd_q);

endmodule

// File: rtl/ccdt_vert.sv
module ccdt_vert
  import ccdt_pkg::*;
#(
  parameter int unsigned FRAME_LINES = 525,
  parameter int unsigned V_POS       = 2,
  parameter int unsigned V_STEP      = 4,
  parameter int unsigned RD_A        = 2,
  parameter int unsigned RD_B        = 28,
  parameter int unsigned RD_W        = 24,
  parameter int unsigned SUB_POS     = 20,
  parameter int unsigned SUB_W       = 15,
  parameter int unsigned V_EFF_LO    = 14,
  parameter int unsigned V_EFF       = 246,
  parameter int unsigned SHUT_W      = 9,
  parameter int unsigned PIX_W       = 10,
  parameter int unsigned LINE_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph,
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] line,
  input  logic [SHUT_W-1:0] shutter,
  output logic [3:0]        v_phase,
  output logic              rd1,
  output logic              rd3,
  output logic              sub,
  output logic              vd,
  output logic              fld,
  output logic              v_eff
);

  localparam int unsigned F0_LINES = (FRAME_LINES + 1) / 2;
  localparam int unsigned F1_LINES = FRAME_LINES - F0_LINES;
  localparam int unsigned N_STEPS  = 3;

  logic [31:0] px, ln, fl, flen, remain;
  logic        fld_n, rd_line, in_a, in_b, in_sub;
  logic [3:0]  v_n;
  logic        rd1_n, rd3_n, sub_n, vd_n, eff_n, shut_en;

  logic [3:0]        v_q;
  logic              rd1_q, rd3_q, sub_q, vd_q, fld_q, eff_q;
  logic [SHUT_W-1:0] shut_q;

  assign px = 32'(pix);
  assign ln = 32'(line);

  always_comb begin
    fld_n   = (ln >= F0_LINES);
    fl      = fld_n ? ln - F0_LINES : ln;
    flen    = fld_n ? F1_LINES : F0_LINES;
    remain  = flen - fl;
    rd_line = (fl == 0);

    v_n = V_IDLE;
    if (!rd_line) begin
      for (int k = 1; k <= N_STEPS; k++) begin
        if (px >= V_POS + (k - 1) * V_STEP && px < V_POS + k * V_STEP)
          v_n = vrot(V_IDLE, k);
      end
    end

    in_a   = (px >= RD_A) && (px < RD_A + RD_W);
    in_b   = (px >= RD_B) && (px < RD_B + RD_W);
    in_sub = (px >= SUB_POS) && (px < SUB_POS + SUB_W);
    rd1_n  = rd_line && (fld_n ? in_b : in_a);
    rd3_n  = rd_line && (fld_n ? in_a : in_b);
    sub_n  = !rd_line && in_sub && (remain > 32'(shut_q));

    vd_n    = (ln == 0) && (px == 0) && !ph;
    shut_en = vd_n;
    eff_n   = (fl >= V_EFF_LO) && (fl < V_EFF_LO + V_EFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= V_IDLE;
      rd1_q  <= 1'b0;
      rd3_q  <= 1'b0;
      sub_q  <= 1'b0;
      vd_q   <= 1'b0;
      fld_q  <= 1'b0;
      eff_q  <= 1'b0;
      shut_q <= '0;
    end else begin
      v_q   <= v_n;
      rd1_q <= rd1_n;
      rd3_q <= rd3_n;
      sub_q <= sub_n;
      vd_q  <= vd_n;
      fld_q <= fld_n;
      eff_q <= eff_n;
      if (shut_en) shut_q <= shutter;
    end
  end

  assign v_phase = v_q;
  assign rd1     = rd1_q;
  assign rd3     = rd3_q;
  assign sub     = sub_q;
  assign vd      = vd_q;
  assign fld     = fld_q;
  assign v_eff   = eff_q;

  a_r6_two_phases: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(v_q) == 2);
  a_r7_idle_on_readout: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_q || rd3_q) |-> (v_q == V_IDLE));
  a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd1_q && rd3_q));
  a_r8_no_drain_on_readout: assert property (@(posedge clk) disable iff (!rst_n)
    !(sub_q && (rd1_q || rd3_q)));
  a_r9_latch_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shut_q) |-> vd_q);
  a_r3_frame_in_field0: assert property (@(posedge clk) disable iff (!rst_n)
    vd_q |-> !fld_q);

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen #(
  parameter int unsigned HBLANK      = 53,
  parameter int unsigned DUMMY       = 16,
  parameter int unsigned OB_LEAD     = 2,
  parameter int unsigned EFF_PIX     = 510,
  parameter int unsigned OB_TRAIL    = 25,
  parameter int unsigned FRAME_LINES = 525,
  parameter int unsigned V_POS       = 2,
  parameter int unsigned V_STEP      = 4,
  parameter int unsigned RD_A        = 2,
  parameter int unsigned RD_B        = 28,
  parameter int unsigned RD_W        = 24,
  parameter int unsigned SUB_POS     = 20,
  parameter int unsigned SUB_W       = 15,
  parameter int unsigned V_START     = 8,
  parameter int unsigned V_OB_LEAD   = 6,
  parameter int unsigned V_EFF       = 246,
  parameter int unsigned SHUT_W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SHUT_W-1:0] shutter_lines,
  output logic [3:0]        v_phase,
  output logic              rd_ph1,
  output logic              rd_ph3,
  output logic              h1,
  output logic              h2,
  output logic              rg,
  output logic              sub_pulse,
  output logic              hd,
  output logic              vd,
  output logic              fld,
  output logic              blk
);

  localparam int unsigned LINE_LEN = HBLANK + DUMMY + OB_LEAD + EFF_PIX + OB_TRAIL;
  localparam int unsigned PIX_W    = $clog2(LINE_LEN);
  localparam int unsigned LINE_W   = $clog2(FRAME_LINES);
  localparam int unsigned EFF_LO   = HBLANK + DUMMY + OB_LEAD;
  localparam int unsigned V_EFF_LO = V_START + V_OB_LEAD;

  logic              ph;
  logic [PIX_W-1:0]  pix;
  logic [LINE_W-1:0] line;
  logic              h_eff, v_eff;

  ccdt_counters #(
    .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES),
    .PIX_W(PIX_W), .LINE_W(LINE_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .ph(ph), .pix(pix), .line(line)
  );

  ccdt_horiz #(
    .HBLANK(HBLANK), .EFF_LO(EFF_LO), .EFF_PIX(EFF_PIX), .PIX_W(PIX_W)
  ) u_hor (
    .clk(clk), .rst_n(rst_n), .ph(ph), .pix(pix),
    .h1(h1), .h2(h2), .rg(rg), .hd(hd), .h_eff(h_eff)
  );

  ccdt_vert #(
    .FRAME_LINES(FRAME_LINES), .V_POS(V_POS), .V_STEP(V_STEP),
    .RD_A(RD_A), .RD_B(RD_B), .RD_W(RD_W),
    .SUB_POS(SUB_POS), .SUB_W(SUB_W),
    .V_EFF_LO(V_EFF_LO), .V_EFF(V_EFF),
    .SHUT_W(SHUT_W), .PIX_W(PIX_W), .LINE_W(LINE_W)
  ) u_ver (
    .clk(clk), .rst_n(rst_n), .ph(ph), .pix(pix), .line(line),
    .shutter(shutter_lines),
    .v_phase(v_phase), .rd1(rd_ph1), .rd3(rd_ph3), .sub(sub_pulse),
    .vd(vd), .fld(fld), .v_eff(v_eff)
  );

  assign blk = ~(h_eff & v_eff);

  a_r3_field_edge_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fld) |-> hd);
  a_r10_open_in_active: assert property (@(posedge clk) disable iff (!rst_n)
    !blk |-> (h1 != h2) && !sub_pulse && !rd_ph1 && !rd_ph3);
  a_r3_vd_with_hd: assert property (@(posedge clk) disable iff (!rst_n)
    vd |-> hd);

endmodule

// File: tb/ccd_timing_gen_test.sv
module ccd_timing_gen_test;

  localparam int CLK_PERIOD = 10;

  localparam int HB   = 12;
  localparam int DUM  = 2;
  localparam int OBL  = 1;
  localparam int EFFP = 4;
  localparam int OBT  = 2;
  localparam int FR   = 21;
  localparam int VP   = 1;
  localparam int VS   = 2;
  localparam int RA   = 1;
  localparam int RB   = 6;
  localparam int RW   = 3;
  localparam int SP   = 7;
  localparam int SW   = 3;
  localparam int VST  = 2;
  localparam int VOB  = 2;
  localparam int VEF  = 4;
  localparam int SHW  = 4;

  localparam int LL     = HB + DUM + OBL + EFFP + OBT;
  localparam int F0     = (FR + 1) / 2;
  localparam int F1     = FR - F0;
  localparam int FC     = 2 * LL * FR;
  localparam int NFRAME = 13;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [SHW-1:0] shutter_lines;
  logic [3:0]     v_phase;
  logic           rd_ph1, rd_ph3, h1, h2, rg, sub_pulse, hd, vd, fld, blk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ccd_timing_gen #(
    .HBLANK(HB), .DUMMY(DUM), .OB_LEAD(OBL), .EFF_PIX(EFFP), .OB_TRAIL(OBT),
    .FRAME_LINES(FR), .V_POS(VP), .V_STEP(VS), .RD_A(RA), .RD_B(RB), .RD_W(RW),
    .SUB_POS(SP), .SUB_W(SW), .V_START(VST), .V_OB_LEAD(VOB), .V_EFF(VEF),
    .SHUT_W(SHW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .shutter_lines(shutter_lines),
    .v_phase(v_phase), .rd_ph1(rd_ph1), .rd_ph3(rd_ph3), .h1(h1), .h2(h2),
    .rg(rg), .sub_pulse(sub_pulse), .hd(hd), .vd(vd), .fld(fld), .blk(blk)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int exp_shut;
    rst_n = 1'b0;
    shutter_lines = '0;
    exp_shut = 0;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1", "v_phase", int'(v_phase), 3);
    chk("R1", "h1", int'(h1), 1);
    chk("R1", "h2", int'(h2), 0);
    chk("R1", "rg", int'(rg), 0);
    chk("R1", "rd", int'({rd_ph1, rd_ph3}), 0);
    chk("R1", "sub", int'(sub_pulse), 0);
    chk("R1", "hd/vd/fld", int'({hd, vd, fld}), 0);
    chk("R1", "blk", int'(blk), 1);

    rst_n = 1'b1;

    for (int s = 0; s < NFRAME * FC; s++) begin
      int sf, fi, ph, p, ln, fl, flen;
      int e_v, e_rd1, e_rd3, e_sub, e_blk, e_h1, e_h2, e_rg, e_hd, e_vd, e_fd;
      bit act, ina, inb;
      string subtag;
      sf = s % FC;
      fi = s / FC;
      if (sf == 0) begin
        exp_shut = fi % 13;
        shutter_lines = SHW'(exp_shut);
      end else if (sf == FC / 2) begin
        shutter_lines = SHW'(15 - exp_shut);  // R9: mid-frame write
      end

      @(posedge clk);
      @(negedge clk);

      ph   = s % 2;
      p    = (s / 2) % LL;
      ln   = (s / (2 * LL)) % FR;
      e_fd = (ln >= F0) ? 1 : 0;
      fl   = e_fd ? ln - F0 : ln;
      flen = e_fd ? F1 : F0;

      e_hd = (p == 0 && ph == 0) ? 1 : 0;
      e_vd = (e_hd == 1 && ln == 0) ? 1 : 0;
      act  = (p >= HB);
      e_h1 = act ? ((ph == 0) ? 1 : 0) : 1;
      e_h2 = act ? ph : 0;
      e_rg = (act && ph == 0) ? 1 : 0;

      e_v = 3;
      if (fl != 0) begin
        for (int k = 1; k <= 3; k++)
          if (p >= VP + (k - 1) * VS && p < VP + k * VS)
            e_v = ((3 << k) | (3 >> (4 - k))) & 15;
      end

      ina   = (p >= RA && p < RA + RW);
      inb   = (p >= RB && p < RB + RW);
      e_rd1 = (fl == 0 && (e_fd ? inb : ina)) ? 1 : 0;
      e_rd3 = (fl == 0 && (e_fd ? ina : inb)) ? 1 : 0;
      e_sub = (fl != 0 && p >= SP && p < SP + SW && (flen - fl) > exp_shut) ? 1 : 0;
      e_blk = (p >= HB + DUM + OBL && p < HB + DUM + OBL + EFFP &&
               fl >= VST + VOB && fl < VST + VOB + VEF) ? 0 : 1;

      subtag = (sf > FC / 2) ? "R9" : "R8";

      chk("R2", "hd", int'(hd), e_hd);
      chk("R3", "vd", int'(vd), e_vd);
      chk("R3", "fld", int'(fld), e_fd);
      chk("R4", "h1/h2", int'({h1, h2}), e_h1 * 2 + e_h2);
      chk("R5", "rg", int'(rg), e_rg);
      chk("R6", "v_phase", int'(v_phase), e_v);
      chk("R7", "rd_ph1", int'(rd_ph1), e_rd1);
      chk("R7", "rd_ph3", int'(rd_ph3), e_rd3);
      chk(subtag, "sub_pulse", int'(sub_pulse), e_sub);
      chk("R10", "blk", int'(blk), e_blk);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule